// File: doc/BRIEF.md
# Two-Wire Serial Voltage-ID Receiver

This block is a write-only slave on a two-wire, I2C-style bus used by a processor to set the supply voltages of two power sections: a core section and a north-bridge section. Both bus lines are brought into the system clock domain through a synchronizer, and start and stop conditions and clock edges are found from the synchronized levels. A transaction is a start, seven address bits and a write bit, an acknowledge, one data byte, a second acknowledge and a stop.

The top three address bits form a fixed prefix. The two lowest address bits choose the section or sections that take the byte. The byte carries a 7-bit voltage code and an active-low flag that permits power-saving operation. Nothing changes at the outputs until the stop condition. At the stop, the addressed section registers are loaded, an "off" indication is derived from the code, and a one-cycle update strobe is raised for each section that was loaded.

Top module: `svid_slave`

## Requirements
- R1: After synchronous reset both voltage codes are 0, both off flags, the power-save permission and both strobes are 0, and the data-line pull-down is released.
- R2: When the first eight bits sampled after a start are a 7-bit address whose bits 6:4 equal 110 followed by a write bit of 0, the block pulls the data line low for the whole of the ninth clock's high period, and it releases the line again while the clock is low.
- R3: If address bits 6:4 differ from 110, or the eighth bit is 1, the block gives no acknowledge on either the ninth or the eighteenth clock, and no output changes at the following stop.
- R4: Address bits 3 and 2 have no effect on acknowledge or on which section is loaded.
- R5: Address bit 1 selects the core section and address bit 0 selects the north-bridge section. When both are set, both sections take the same code. When neither is set, no section changes.
- R6: After an accepted address, the block acknowledges again on the clock that follows the eight data bits, with the line held low through that clock's high period.
- R7: Data bit 7 is an active-low power-save flag. The power-save output becomes the inverse of that bit whenever at least one section is addressed. Data bits 6:0 form the voltage code. All bits travel MSB first and are sampled on the rising clock edge.
- R8: The voltage codes change only at a stop that ends a complete, acknowledged transaction. The update strobe of each loaded section is high for exactly one system clock cycle, and no strobe occurs in any other case.
- R9: A code from 124 to 127 (binary 11111xx) sets the off flag of each addressed section, and any other code clears it. A section that is not addressed keeps its code and its off flag.
- R10: A start condition in the middle of a transaction, including after the data acknowledge and before the stop, discards all bits received so far and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| core_vid | output | 7 | Committed core section voltage code |
| nb_vid | output | 7 | Committed north-bridge section voltage code |
| core_off | output | 1 | Core section commanded off |
| nb_off | output | 1 | North-bridge section commanded off |
| ps_allow | output | 1 | 1 = power-saving operation permitted |
| core_upd | output | 1 | One-cycle strobe when the core code is loaded |
| nb_upd | output | 1 | One-cycle strobe when the north-bridge code is loaded |

## Verification
The hardest situation to reach from the ports is a complete, doubly acknowledged transaction that is abandoned by a repeated start while the block sits between the data acknowledge and the stop. The bench models the open-drain data line as the AND of the master's drive and the block's release, so it can build that sequence bit by bit, and it also aborts in the middle of a data byte. Around these cases it sweeps every address prefix, every section selection and both write-bit values with varying ignored bits, and then drives all 128 voltage codes across the three selection patterns. It compares the outputs and the strobe counts with a model kept in the bench.

// File: rtl/svid_pkg.sv
package svid_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int VID_W   = 7;
    localparam int NSEC    = 2;          // index 1 = core, index 0 = north-bridge
    localparam int PFX_W   = 3;
    localparam logic [PFX_W-1:0] PREFIX = 3'b110;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int OFF_MIN = 124;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_HOLD,
        ST_SKIP
    } frame_st_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic [NSEC-1:0]  sel;
        logic             ps_n;
        logic [VID_W-1:0] code;
    } cmd_t;

    function automatic logic addr_accept(input logic [PFX_W-1:0] pfx, input logic rd);
        return (pfx == PREFIX) && !rd;
    endfunction

    function automatic logic code_is_off(input logic [VID_W-1:0] code);
        return int'(code) >= OFF_MIN;
    endfunction

endpackage

// File: rtl/svid_sync.sv
module svid_sync
    import svid_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    // idle bus is high on both lines
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/svid_frame.sv
module svid_frame
    import svid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    sda_pull,
    output logic    cmd_valid,
    output cmd_t    cmd
);

    frame_st_t         state;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-2:0] shreg;
    logic [DATA_W-1:0] rx_byte;
    logic [NSEC-1:0]   sel_q;
    logic [DATA_W-1:0] data_q;
    logic              ack_on;
    logic              last_bit;

    assign rx_byte  = {shreg, ev.sda};
    assign last_bit = (bitcnt == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            sel_q     <= '0;
            data_q    <= '0;
            ack_on    <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                shreg  <= '0;
                ack_on <= 1'b0;
            end else if (ev.stop) begin
                if (state == ST_HOLD) cmd_valid <= 1'b1;
                state  <= ST_IDLE;
                ack_on <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (ev.scl_rise) begin
                        shreg <= rx_byte[DATA_W-2:0];
                        if (last_bit) begin
                            bitcnt <= '0;
                            if (addr_accept(rx_byte[DATA_W-1 -: PFX_W], rx_byte[0])) begin
                                state <= ST_AACK;
                                sel_q <= rx_byte[NSEC:1];
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_DATA: if (ev.scl_rise) begin
                        shreg <= rx_byte[DATA_W-2:0];
                        if (last_bit) begin
                            bitcnt <= '0;
                            data_q <= rx_byte;
                            state  <= ST_DACK;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_AACK, ST_DACK: if (ev.scl_fall) begin
                        // first fall ends the 8th bit, second fall ends the ack clock
                        if (!ack_on) begin
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            state  <= (state == ST_AACK) ? ST_DATA : ST_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = ack_on;

    always_comb begin
        cmd.sel  = sel_q;
        cmd.ps_n = data_q[DATA_W-1];
        cmd.code = data_q[VID_W-1:0];
    end

    // R2 R6: the pull-down only turns on while the bus clock is low
    ack_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);

    // R2 R6: the pull-down only turns off while the bus clock is low
    ack_off_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> !ev.scl);

    // R8
    commit_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(ev.stop));

endmodule

// File: rtl/svid_commit.sv
module svid_commit
    import svid_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  cmd_t                       cmd,
    output logic [NSEC-1:0][VID_W-1:0] vid_o,
    output logic [NSEC-1:0]            off_o,
    output logic [NSEC-1:0]            upd_o,
    output logic                       ps_allow
);

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst) begin
                vid_o[g] <= '0;
                off_o[g] <= 1'b0;
                upd_o[g] <= 1'b0;
            end else begin
                upd_o[g] <= cmd_valid & cmd.sel[g];
                if (cmd_valid && cmd.sel[g]) begin
                    vid_o[g] <= cmd.code;
                    off_o[g] <= code_is_off(cmd.code);
                end
            end
        end

        // R8
        stable_vid_chk: assert property (@(posedge clk) disable iff (rst)
            !upd_o[g] |-> $stable(vid_o[g]));

        // R9
        off_range_chk: assert property (@(posedge clk) disable iff (rst)
            off_o[g] |-> (vid_o[g][VID_W-1:2] == '1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_allow <= 1'b0;
        end else if (cmd_valid && (cmd.sel != '0)) begin
            ps_allow <= ~cmd.ps_n;
        end
    end

endmodule

// File: rtl/svid_slave.sv
module svid_slave
    import svid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    output logic [VID_W-1:0] core_vid,
    output logic [VID_W-1:0] nb_vid,
    output logic             core_off,
    output logic             nb_off,
    output logic             ps_allow,
    output logic             core_upd,
    output logic             nb_upd
);

    bus_ev_t                    ev;
    logic                       cmd_valid;
    cmd_t                       cmd;
    logic [NSEC-1:0][VID_W-1:0] vid_w;
    logic [NSEC-1:0]            off_w;
    logic [NSEC-1:0]            upd_w;

    svid_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    svid_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_pull  (sda_pull),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    svid_commit u_commit (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .vid_o     (vid_w),
        .off_o     (off_w),
        .upd_o     (upd_w),
        .ps_allow  (ps_allow)
    );

    assign core_vid = vid_w[1];
    assign nb_vid   = vid_w[0];
    assign core_off = off_w[1];
    assign nb_off   = off_w[0];
    assign core_upd = upd_w[1];
    assign nb_upd   = upd_w[0];

endmodule

// File: tb/svid_slave_test.sv
module svid_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;      // system clocks per bus quarter
    localparam int WATCHDOG   = 180000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    logic [6:0] core_vid, nb_vid;
    logic core_off, nb_off, ps_allow, core_upd, nb_upd;

    int checks = 0;
    int errors = 0;
    int cu_cnt = 0;
    int nu_cnt = 0;
    bit done = 0;

    logic [6:0] e_core = '0, e_nb = '0;
    logic e_coff = 0, e_noff = 0, e_ps = 0;
    int e_cu = 0, e_nu = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svid_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .core_vid(core_vid), .nb_vid(nb_vid),
        .core_off(core_off), .nb_off(nb_off), .ps_allow(ps_allow),
        .core_upd(core_upd), .nb_upd(nb_upd)
    );

    always @(negedge clk) begin
        if (!rst && core_upd) cu_cnt++;
        if (!rst && nb_upd) nu_cnt++;
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1; waitc(Q); scl = 1; waitc(Q);
        sda_m = 0; waitc(Q); scl = 0; waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; waitc(Q); scl = 1; waitc(Q); sda_m = 1; waitc(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; waitc(Q); scl = 1; waitc(Q); scl = 0; waitc(Q);
    endtask

    task automatic ack_clock(output logic [1:0] seen);
        sda_m = 1; waitc(Q); seen[1] = sda_pull;
        scl = 1; waitc(Q); seen[0] = sda_pull & ~sda_line;
        scl = 0; waitc(Q);
    endtask

    task automatic xact(input logic [6:0] addr, input logic rd, input logic [7:0] data,
                        input bit stop, output logic [1:0] a1, output logic [1:0] a2);
        bus_start();
        for (int i = 6; i >= 0; i--) send_bit(addr[i]);
        send_bit(rd);
        ack_clock(a1);
        for (int i = 7; i >= 0; i--) send_bit(data[i]);
        ack_clock(a2);
        if (stop) bus_stop();
    endtask

    function automatic bit accepted(input logic [6:0] addr, input logic rd);
        return (addr[6:4] == 3'b110) && !rd;
    endfunction

    task automatic model(input logic [6:0] addr, input logic rd, input logic [7:0] data);
        if (accepted(addr, rd)) begin
            if (addr[1]) begin e_core = data[6:0]; e_coff = (data[6:0] >= 124); e_cu++; end
            if (addr[0]) begin e_nb = data[6:0]; e_noff = (data[6:0] >= 124); e_nu++; end
            if (addr[1] | addr[0]) e_ps = ~data[7];
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " R5 core_vid"}, core_vid, e_core);
        check({tag, " R5 nb_vid"}, nb_vid, e_nb);
        check({tag, " R9 core_off"}, core_off, e_coff);
        check({tag, " R9 nb_off"}, nb_off, e_noff);
        check({tag, " R7 ps_allow"}, ps_allow, e_ps);
        check({tag, " R8 core strobes"}, cu_cnt, e_cu);
        check({tag, " R8 nb strobes"}, nu_cnt, e_nu);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] a1, a2;
        logic [6:0] addr;
        logic [7:0] data;

        waitc(5);
        rst = 0;
        waitc(3);
        // R1 reset state
        check("R1 core_vid", core_vid, 0);
        check("R1 nb_vid", nb_vid, 0);
        check("R1 offs", {core_off, nb_off}, 0);
        check("R1 ps_allow", ps_allow, 0);
        check("R1 strobes", {core_upd, nb_upd}, 0);
        check("R1 sda_pull", sda_pull, 0);

        // R2 R3 R4 R5 R6: sweep prefixes, selections, direction, ignored bits
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    addr = {p[2:0], 2'(p + s + rw), s[1:0]};
                    data = {p[0] ^ s[0], 7'(p * 16 + s * 4 + rw * 2 + 3)};
                    xact(addr, rw[0], data, 1, a1, a2);
                    waitc(4);
                    check("R2 R3 R4 address ack", a1, accepted(addr, rw[0]) ? 3 : 0);
                    check("R6 R3 data ack", a2, accepted(addr, rw[0]) ? 3 : 0);
                    model(addr, rw[0], data);
                    compare("sweep");
                end
            end
        end

        // R9 R7 R5: every code over the three selection patterns
        for (int c = 0; c < 128; c++) begin
            addr = {3'b110, 2'(c), 2'((c % 3) + 1)};
            data = {c[1], c[6:0]};
            xact(addr, 1'b0, data, 1, a1, a2);
            waitc(4);
            check("R2 ack code sweep", {a1, a2}, 15);
            model(addr, 1'b0, data);
            compare("codes");
        end

        // R8: complete transaction held without stop changes nothing
        addr = 7'b1100011; data = 8'h15;
        xact(addr, 1'b0, data, 0, a1, a2);
        waitc(3 * Q);
        compare("R8 before stop");
        bus_stop();
        waitc(4);
        model(addr, 1'b0, data);
        compare("R8 after stop");

        // R10: repeated start inside the data byte
        bus_start();
        for (int i = 6; i >= 0; i--) send_bit(addr[i]);
        send_bit(1'b0);
        ack_clock(a1);
        check("R10 first ack", a1, 3);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        addr = 7'b1100001; data = 8'h9a;
        xact(addr, 1'b0, data, 1, a1, a2);
        waitc(4);
        check("R10 restarted acks", {a1, a2}, 15);
        model(addr, 1'b0, data);
        compare("R10 mid byte");

        // R10: repeated start after data ack, before stop
        xact(7'b1100010, 1'b0, 8'h7e, 0, a1, a2);
        addr = 7'b1100001; data = 8'h22;
        xact(addr, 1'b0, data, 1, a1, a2);
        waitc(4);
        model(addr, 1'b0, data);
        compare("R10 after ack");

        // R3: rejected address keeps bus ignored until next start
        xact(7'b1010011, 1'b0, 8'h00, 1, a1, a2);
        waitc(4);
        check("R3 no ack", {a1, a2}, 0);
        compare("R3 ignore");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule